// File: doc/BRIEF.md
# Configurable Serial Transmit Framer

The block turns parallel bytes into an asynchronous serial character stream on a single line output. Its frame format is held in an 8-bit control register written through a one-cycle write strobe. The register sets the character length (5 to 8 bits), one of four parity kinds or no parity, and a long or short stop period. It also holds a break bit that forces the line low. One more bit is a divisor-latch enable, which belongs to the baud divisor and has no effect on framing here.

Bytes arrive on a valid/ready handshake and are accepted only while the framer is idle. An external divisor supplies a 16x oversample enable. Every serial bit lasts 16 of those enables, except that the stop period can be stretched to 1.5 or 2 bit times. The control fields are copied into a frame shadow when a byte is accepted. A write made during a character therefore shapes only the characters that follow it.

The state machine has five states. IDLE moves to START when a byte is accepted. START moves to DATA when its bit time ends. DATA moves to PARITY after the last data bit if parity is enabled, and to STOP otherwise. PARITY moves to STOP when its bit time ends. STOP moves to IDLE when the stop period ends.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset, and whenever no character is being sent and break is clear, `txd` is 1 and `in_ready` is 1. The control register resets to 0x00.
- R2: A character is a start bit of 0, followed by the data bits least significant bit first. Each start, data and parity bit lasts exactly 16 `tick` pulses, counted from the first pulse after the accepting clock edge.
- R3: Control bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: When control bit 2 is 0, the stop period is 16 ticks of line level 1. When bit 2 is 1 it is 32 ticks for 6, 7 or 8 data bits, and 24 ticks for 5 data bits.
- R5: When control bit 3 is 0, no parity bit is sent, whatever bits 5 and 4 hold.
- R6: With bits [5:3] = 001, the parity bit makes the count of ones in data plus parity odd. With 011 it makes that count even. With 101 the parity bit is 1, and with 111 it is 0. The parity bit follows the last data bit.
- R7: While control bit 6 is 1, `txd` is 0 whatever the framer is doing. Clearing bit 6 returns the line to the framer's level at once.
- R8: Control bit 7 has no effect on the transmitted waveform or on its timing.
- R9: A control write made while a character is in flight does not change that character. It applies from the next accepted byte onward.
- R10: `in_ready` is 1 only in IDLE. A byte is taken on the clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the edge that consumes the final stop tick, and is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| tick | input | 1 | 16x oversample enable from the divisor |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Framer idle and able to take a byte |
| txd | output | 1 | Serial line output |

## Verification
The assertions assume that `tick` is a single-cycle enable and that the upstream side holds `in_data` steady while `in_valid` waits for `in_ready`. The stimulus raises `tick` on every second clock, so it is never high for two cycles in a row. It offers a byte only after seeing `in_ready` high, and drops `in_valid` right after the accepting edge. Control writes are never placed on the same edge as an acceptance, so the handover from live register to frame shadow is always well ordered.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Frame-format fields held for the whole of one character
    typedef struct packed {
        logic       stick;      // parity bit forced to a constant
        logic       even;       // even parity / forced value select
        logic       par_en;     // parity bit present
        logic       stop_long;  // long stop period
        logic [1:0] wsel;       // data bits minus five
    } frame_cfg_t;

endpackage

// File: rtl/line_ctl_reg.sv
module line_ctl_reg
    import uart_tx_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             load,
    output logic             brk,
    output frame_cfg_t       fcfg
);

    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata;
        end
    end

    // Shadow copy taken only at a character boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcfg <= '0;
        end else if (load) begin
            fcfg.wsel      <= ctl_q[1:0];
            fcfg.stop_long <= ctl_q[2];
            fcfg.par_en    <= ctl_q[3];
            fcfg.even      <= ctl_q[4];
            fcfg.stick     <= ctl_q[5];
        end
    end

    assign brk = ctl_q[6];

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(fcfg));

endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] count;

    assign done = tick && (count == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (tick) begin
            if (done) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    // R2
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));

endmodule

// File: rtl/tx_fsm.sv
module tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = $clog2(2 * OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  frame_cfg_t        fcfg,
    input  logic              bit_done,
    output logic              restart,
    output logic              load,
    output logic [CNT_W-1:0]  limit,
    output logic              line
);

    localparam int IDX_W    = $clog2(DATA_W + 1);
    localparam int LIM_BIT  = OVS - 1;
    localparam int LIM_HALF = OVS + OVS / 2 - 1;
    localparam int LIM_TWO  = 2 * OVS - 1;

    tx_state_e         state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_last;
    logic              acc;
    logic              par_bit;
    logic              accept;

    assign accept   = in_valid && (state == ST_IDLE);
    assign idx_last = IDX_W'(4) + IDX_W'(fcfg.wsel);
    assign par_bit  = fcfg.stick ? ~fcfg.even : (fcfg.even ? acc : ~acc);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept)   nxt = ST_START;
            ST_START:  if (bit_done) nxt = ST_DATA;
            ST_DATA:   if (bit_done && idx == idx_last)
                           nxt = fcfg.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) nxt = ST_STOP;
            ST_STOP:   if (bit_done) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Shift register, bit index and running parity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            acc   <= 1'b0;
        end else if (accept) begin
            shreg <= in_data;
            idx   <= '0;
            acc   <= 1'b0;
        end else if (state == ST_DATA && bit_done) begin
            shreg <= shreg >> 1;
            acc   <= acc ^ shreg[0];
            idx   <= idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        restart  = 1'b0;
        load     = 1'b0;
        limit    = CNT_W'(LIM_BIT);
        line     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                restart  = accept;
                load     = accept;
            end
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_bit;
            ST_STOP: begin
                if (fcfg.stop_long) begin
                    limit = (fcfg.wsel == 2'b00) ? CNT_W'(LIM_HALF) : CNT_W'(LIM_TWO);
                end
            end
            default: line = 1'b1;
        endcase
    end

    // R10
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (state == ST_START));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !in_valid) |=> (state == ST_IDLE));

    // R3
    data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (idx <= idx_last));

    // R5
    no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |-> fcfg.par_en);

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTL_W-1:0]  cfg_wdata,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd
);

    localparam int CNT_W = $clog2(2 * OVS);

    frame_cfg_t       fcfg;
    logic             brk;
    logic             load;
    logic             restart;
    logic             bit_done;
    logic [CNT_W-1:0] limit;
    logic             line;

    line_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .load  (load),
        .brk   (brk),
        .fcfg  (fcfg)
    );

    bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .done    (bit_done)
    );

    tx_fsm #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .fcfg     (fcfg),
        .bit_done (bit_done),
        .restart  (restart),
        .load     (load),
        .limit    (limit),
        .line     (line)
    );

    assign txd = brk ? 1'b0 : line;

endmodule

// File: tb/serial_tx_framer_test.sv
`timescale 1ns/1ps
module serial_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    serial_tx_framer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tick      (tick),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .txd       (txd)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        tick = 1'b0;
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Sends one byte and compares every tick-sampled line level with the
    // frame computed from ctl (the control value in force at acceptance).
    task automatic send_frame(input logic [7:0] ctl, input logic [7:0] d,
                              input bit mid_en, input logic [7:0] mid_ctl);
        int  wl      = 5 + int'(ctl[1:0]);
        bit  pen     = ctl[3];
        int  stop_t  = ctl[2] ? ((wl == 5) ? 24 : 32) : 16;
        int  total   = 16 * (1 + wl + int'(pen)) + stop_t;
        bit  ones    = 1'b0;
        bit  par;
        bit  rdy_bad = 1'b0;
        bit  ph      = 1'b0;
        int  k       = 0;
        for (int i = 0; i < wl; i++) ones ^= d[i];
        if (ctl[5]) par = ~ctl[4];          // R6 forced values
        else if (ctl[4]) par = ones;        // R6 even
        else par = ~ones;                   // R6 odd

        @(negedge clk);
        tick = 1'b0;
        check("R10 ready before offer", in_ready, 1'b1);
        in_valid = 1'b1;
        in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 ready drop after accept", in_ready, 1'b0);
        while (k < total) begin
            @(negedge clk);
            if (cfg_we) cfg_we = 1'b0;
            ph = ~ph;
            tick = ph;
            if (ph) begin
                int  pos = k / 16;
                bit  e;
                string tag;
                if (pos == 0) begin e = 1'b0; tag = "R2 start"; end
                else if (pos <= wl) begin e = d[pos-1]; tag = "R3 data"; end
                else if (pen && pos == wl + 1) begin e = par; tag = "R6 parity"; end
                else begin e = 1'b1; tag = "R4 stop"; end
                if (ctl[6]) begin e = 1'b0; tag = "R7 break"; end
                check(tag, txd, e);
                if (in_ready) rdy_bad = 1'b1;
                if (mid_en && k == 40) begin
                    cfg_we = 1'b1;
                    cfg_wdata = mid_ctl;
                end
                k++;
            end
        end
        check("R10 ready low through frame", rdy_bad, 1'b0);
        @(negedge clk);
        tick = 1'b0;
        cfg_we = 1'b0;
        check("R10 ready after last stop tick", in_ready, 1'b1);
        check("R1 idle line", txd, ctl[6] ? 1'b0 : 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset txd", txd, 1'b1);
        check("R1 reset ready", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle txd", txd, 1'b1);

        // R1 reset control value 0x00: 5 bits, short stop, no parity
        send_frame(8'h00, 8'h3C, 1'b0, 8'h00);

        // Sweep word length, stop length and all parity codes (R2-R6);
        // bit 7 toggled along the way (R8)
        for (int i = 0; i < 64; i++) begin
            logic [7:0] c;
            c = {i[0] ^ i[3], 1'b0, 6'(i)};
            write_ctl(c);
            send_frame(c, 8'hA5 ^ 8'(i * 37), 1'b0, 8'h00);
        end

        // R8: same frame with bit 7 set and clear
        write_ctl(8'h9B);
        send_frame(8'h9B, 8'h6E, 1'b0, 8'h00);
        write_ctl(8'h1B);
        send_frame(8'h1B, 8'h6E, 1'b0, 8'h00);

        // R9: mid-frame write keeps current frame, applies to next
        write_ctl(8'h00);
        send_frame(8'h00, 8'hC9, 1'b1, 8'h1F);
        send_frame(8'h1F, 8'hC9, 1'b0, 8'h00);
        write_ctl(8'h3E);
        send_frame(8'h3E, 8'h52, 1'b1, 8'h08);
        send_frame(8'h08, 8'h52, 1'b0, 8'h00);

        // R7: break while idle, during a frame, then release
        write_ctl(8'h43);
        repeat (4) begin
            @(negedge clk);
            check("R7 break idle", txd, 1'b0);
        end
        send_frame(8'h43, 8'hFF, 1'b0, 8'h00);
        write_ctl(8'h03);
        @(negedge clk);
        check("R7 break released", txd, 1'b1);
        send_frame(8'h03, 8'h81, 1'b0, 8'h00);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule